// File: doc/BRIEF.md
# Rotating Register Stack for an Accumulator-Style Floating-Point Unit

This block holds eight 80-bit operand registers that are addressed relative to a moving top-of-stack pointer instead of by a fixed index. Relative slot 0 is the top and acts as the accumulator. It is the left operand and the destination of every dyadic operation. Relative slot k sits k positions below the top. Values enter with a push, are combined, and leave with a pop. A write command replaces the top in place. An exchange swaps the top with any other relative slot in a single clock.

Two combinational read ports serve a dyadic operation. Port A always returns the top. Port B returns the slot just below the top, or a relative slot that the caller selects. Each physical slot carries a valid tag. The block raises an overflow pulse when a push would land on a valid slot. It raises an underflow pulse when an operation needs a slot that is empty. The block also watches a raw two-byte instruction stream and performs an exchange by itself when it sees the exchange encoding. Arithmetic stays outside the block.

Top module: `fpstk_rot_stack`

## Requirements
- R1: After reset the top pointer `tos_o` is 0, both flags are low, and every slot is empty, so a pop right after reset raises underflow.
- R2: A push (op_code 1) on an empty target first decrements the top pointer modulo 8, then writes `wr_data` there and marks that slot valid. The old top becomes relative slot 1.
- R3: A push whose target slot is already valid raises `ovf_o` and leaves the pointer and all contents unchanged.
- R4: A pop (op_code 2) on a valid top clears the top's tag and increments the pointer modulo 8. A pop on an empty top raises `unf_o` and changes nothing.
- R5: `rd_a` always shows relative slot 0. `rd_b` shows relative slot 1 when `use_sel` is low, and relative slot `sel_idx` when it is high. A read command (op_code 5) raises `unf_o` if either addressed slot is empty.
- R6: A write-top command (op_code 3) replaces relative slot 0 with `wr_data` and marks it valid. The pointer does not move.
- R7: An exchange command (op_code 4) swaps relative slot 0 with relative slot `sel_idx`. If either slot is empty, the block raises `unf_o` and swaps nothing.
- R8: An exchange of relative slot 0 with itself changes nothing and raises no flag.
- R9: When `ins_valid` is high, `ins_b0` is D9h and `ins_b1[7:3]` is 11001b, the block exchanges relative slot 0 with relative slot `ins_b1[2:0]`, with the same rules as R7 and R8. Any other byte pair is ignored.
- R10: When `op_valid` and a matching instruction fall in the same cycle, the command is executed and the decoded exchange is dropped.
- R11: Each flag is a pulse that lasts one cycle, in the cycle after the operation that caused it. Op codes 0, 6 and 7, or no request at all, change no state and raise no flag.
- R12: The top pointer wraps: a push from 0 gives 7, and a pop from 7 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Command request |
| op_code | input | 3 | 0 none, 1 push, 2 pop, 3 write top, 4 exchange, 5 read |
| sel_idx | input | 3 | Relative slot for port B and for the exchange command |
| use_sel | input | 1 | Port B returns slot `sel_idx` instead of slot 1 |
| wr_data | input | 80 | Data for push and write top |
| ins_valid | input | 1 | Instruction byte pair present |
| ins_b0 | input | 8 | First instruction byte |
| ins_b1 | input | 8 | Second instruction byte |
| rd_a | output | 80 | Relative slot 0 |
| rd_b | output | 80 | Relative slot 1 or slot `sel_idx` |
| tos_o | output | 3 | Physical index of the top |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |

## Verification
The command port and the instruction decoder can both ask for a state change in the same cycle. The bench provokes this by issuing a write-top command while a valid exchange byte pair (D9h C9h) is on the instruction inputs. The result is judged afterwards through the read ports. Slot 0 must hold the written value, and slot 1 must still hold its old contents, which would have moved if the decoded exchange had also run. The bench also checks that the pointer did not move.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
   typedef enum logic [2:0] {
      FPS_NOP   = 3'd0,
      FPS_PUSH  = 3'd1,
      FPS_POP   = 3'd2,
      FPS_WRTOP = 3'd3,
      FPS_XCHG  = 3'd4,
      FPS_READ  = 3'd5
   } fps_op_e;

   localparam logic [7:0] FPS_XCHG_LEAD = 8'hD9;
   localparam logic [4:0] FPS_XCHG_HI5  = 5'b11001;
endpackage

// File: rtl/fpstk_relmap.sv
// Turns a stack-relative position into a physical slot index.
module fpstk_relmap #(
   parameter int IDX_W = 3
) (
   input  logic [IDX_W-1:0] top,
   input  logic [IDX_W-1:0] rel,
   output logic [IDX_W-1:0] phys
);
   // The depth is a power of two, so the wrap is the natural carry-out loss.
   assign phys = top + rel;
endmodule

// File: rtl/fpstk_xchg_dec.sv
// Recognises the two-byte exchange encoding on the raw instruction stream.
module fpstk_xchg_dec
   import fpstk_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int IDX_W = 3
) (
   input  logic             ins_valid,
   input  logic [7:0]       ins_b0,
   input  logic [7:0]       ins_b1,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);
   logic in_range;

   assign in_range = ({5'd0, ins_b1[2:0]} < 8'(DEPTH));
   assign hit      = ins_valid && (ins_b0 == FPS_XCHG_LEAD) &&
                     (ins_b1[7:3] == FPS_XCHG_HI5) && in_range;
   assign idx      = ins_b1[IDX_W-1:0];
endmodule

// File: rtl/fpstk_slots.sv
// Physical slot storage: data plus valid tag, two write ports, three read ports.
module fpstk_slots #(
   parameter int DATA_W = 80,
   parameter int DEPTH  = 8,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wa_en,
   input  logic [IDX_W-1:0]  wa_addr,
   input  logic [DATA_W-1:0] wa_data,
   input  logic              wa_tag,
   input  logic              wb_en,
   input  logic [IDX_W-1:0]  wb_addr,
   input  logic [DATA_W-1:0] wb_data,
   input  logic              wb_tag,
   input  logic [IDX_W-1:0]  ra_addr,
   output logic [DATA_W-1:0] ra_data,
   output logic              ra_tag,
   input  logic [IDX_W-1:0]  rb_addr,
   output logic [DATA_W-1:0] rb_data,
   output logic              rb_tag,
   input  logic [IDX_W-1:0]  rc_addr,
   output logic [DATA_W-1:0] rc_data,
   output logic              rc_tag
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]  tag;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag[g] <= 1'b0;
         end else if (wa_en && wa_addr == SLOT) begin
            mem[g] <= wa_data;
            tag[g] <= wa_tag;
         end else if (wb_en && wb_addr == SLOT) begin
            mem[g] <= wb_data;
            tag[g] <= wb_tag;
         end
      end
   end

   assign ra_data = mem[ra_addr];
   assign ra_tag  = tag[ra_addr];
   assign rb_data = mem[rb_addr];
   assign rb_tag  = tag[rb_addr];
   assign rc_data = mem[rc_addr];
   assign rc_tag  = tag[rc_addr];
endmodule

// File: rtl/fpstk_rot_stack.sv
// Eight-entry register stack addressed relative to a moving top pointer.
module fpstk_rot_stack
   import fpstk_pkg::*;
#(
   parameter int DATA_W = 80,
   parameter int DEPTH  = 8,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [IDX_W-1:0]  sel_idx,
   input  logic              use_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ins_valid,
   input  logic [7:0]        ins_b0,
   input  logic [7:0]        ins_b1,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b,
   output logic [IDX_W-1:0]  tos_o,
   output logic              ovf_o,
   output logic              unf_o
);
   localparam logic [IDX_W-1:0] REL_ONE   = IDX_W'(1);
   localparam logic [IDX_W-1:0] REL_MINUS = '1;

   if ((1 << IDX_W) != DEPTH || DEPTH < 2 || DEPTH > 8) begin : g_bad_depth
      $error("fpstk_rot_stack: DEPTH must be a power of two from 2 to 8");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("fpstk_rot_stack: DATA_W must be positive");
   end

   fps_op_e          op;
   logic [IDX_W-1:0] tos_q, tos_n;
   logic             ovf_n, unf_n;
   logic [IDX_W-1:0] below_phys, sel_phys, newtop_phys, xchg_phys;
   logic             dec_hit;
   logic [IDX_W-1:0] dec_idx;
   logic             cmd_xchg, dec_go, xchg_go;
   logic [IDX_W-1:0] xchg_idx;

   logic              wa_en, wb_en, wa_tag, wb_tag;
   logic [IDX_W-1:0]  wa_addr, wb_addr, rb_addr, rc_addr;
   logic [DATA_W-1:0] wa_data, wb_data;
   logic [DATA_W-1:0] ra_data, rb_data, rc_data;
   logic              ra_tag, rb_tag, rc_tag;

   assign op = fps_op_e'(op_code);

   fpstk_relmap #(.IDX_W(IDX_W)) u_map_below (
      .top(tos_q), .rel(REL_ONE), .phys(below_phys));
   fpstk_relmap #(.IDX_W(IDX_W)) u_map_sel (
      .top(tos_q), .rel(sel_idx), .phys(sel_phys));
   fpstk_relmap #(.IDX_W(IDX_W)) u_map_push (
      .top(tos_q), .rel(REL_MINUS), .phys(newtop_phys));
   fpstk_relmap #(.IDX_W(IDX_W)) u_map_xchg (
      .top(tos_q), .rel(xchg_idx), .phys(xchg_phys));

   fpstk_xchg_dec #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dec (
      .ins_valid(ins_valid), .ins_b0(ins_b0), .ins_b1(ins_b1),
      .hit(dec_hit), .idx(dec_idx));

   // Command port wins; a decoded exchange only runs in an otherwise idle cycle.
   assign cmd_xchg = op_valid && (op == FPS_XCHG);
   assign dec_go   = !op_valid && dec_hit;
   assign xchg_go  = cmd_xchg || dec_go;
   assign xchg_idx = cmd_xchg ? sel_idx : dec_idx;

   assign rb_addr = use_sel ? sel_phys : below_phys;
   assign rc_addr = (op_valid && op == FPS_PUSH) ? newtop_phys : xchg_phys;

   fpstk_slots #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_slots (
      .clk(clk), .rst_n(rst_n),
      .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data), .wa_tag(wa_tag),
      .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data), .wb_tag(wb_tag),
      .ra_addr(tos_q), .ra_data(ra_data), .ra_tag(ra_tag),
      .rb_addr(rb_addr), .rb_data(rb_data), .rb_tag(rb_tag),
      .rc_addr(rc_addr), .rc_data(rc_data), .rc_tag(rc_tag));

   always_comb begin
      tos_n   = tos_q;
      ovf_n   = 1'b0;
      unf_n   = 1'b0;
      wa_en   = 1'b0;
      wa_addr = tos_q;
      wa_data = wr_data;
      wa_tag  = 1'b1;
      wb_en   = 1'b0;
      wb_addr = xchg_phys;
      wb_data = ra_data;
      wb_tag  = 1'b1;
      if (xchg_go) begin
         if (xchg_idx != '0) begin
            if (!ra_tag || !rc_tag) begin
               unf_n = 1'b1;
            end else begin
               wa_en   = 1'b1;
               wa_data = rc_data;
               wb_en   = 1'b1;
            end
         end
      end else if (op_valid) begin
         unique case (op)
            FPS_PUSH: begin
               if (rc_tag) begin
                  ovf_n = 1'b1;
               end else begin
                  wa_en   = 1'b1;
                  wa_addr = newtop_phys;
                  tos_n   = newtop_phys;
               end
            end
            FPS_POP: begin
               if (!ra_tag) begin
                  unf_n = 1'b1;
               end else begin
                  wa_en   = 1'b1;
                  wa_data = ra_data;
                  wa_tag  = 1'b0;
                  tos_n   = below_phys;
               end
            end
            FPS_WRTOP: wa_en = 1'b1;
            FPS_READ:  unf_n = !ra_tag || !rb_tag;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tos_q <= '0;
         ovf_o <= 1'b0;
         unf_o <= 1'b0;
      end else begin
         tos_q <= tos_n;
         ovf_o <= ovf_n;
         unf_o <= unf_n;
      end
   end

   assign rd_a  = ra_data;
   assign rd_b  = rb_data;
   assign tos_o = tos_q;
endmodule

// File: rtl/fpstk_rot_stack_chk.sv
module fpstk_rot_stack_chk #(
   parameter int DATA_W = 80,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_code,
   input logic [DATA_W-1:0] wr_data,
   input logic              ins_valid,
   input logic [DATA_W-1:0] rd_a,
   input logic [IDX_W-1:0]  tos_o,
   input logic              ovf_o,
   input logic              unf_o
);
   // R2 / R12: a push that is not refused moves the top down by one, with wrap
   assert_push_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 3'd1) |=>
         (ovf_o || tos_o == IDX_W'($past(tos_o) - 1'b1)));

   // R2: the pushed value is visible on port A
   assert_push_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 3'd1) |=> (ovf_o || rd_a == $past(wr_data)));

   // R3: a refused push leaves the pointer in place
   assert_no_overflow_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 3'd1) |=> (!ovf_o || $stable(tos_o)));

   // R4 / R12: a pop that is not refused moves the top up by one, with wrap
   assert_pop_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 3'd2) |=>
         (unf_o || tos_o == IDX_W'($past(tos_o) + 1'b1)));

   // R6 / R7: write-top, exchange and read never move the pointer
   assert_pointer_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == 3'd3 || op_code == 3'd4 || op_code == 3'd5))
         |=> $stable(tos_o));

   // R11: an idle cycle changes nothing and raises no flag
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !ins_valid) |=> ($stable(tos_o) && !ovf_o && !unf_o));

   // R11: one operation never raises both flags
   assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_o && unf_o));
endmodule

bind fpstk_rot_stack fpstk_rot_stack_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
   .wr_data(wr_data), .ins_valid(ins_valid), .rd_a(rd_a), .tos_o(tos_o),
   .ovf_o(ovf_o), .unf_o(unf_o));

// File: tb/fpstk_rot_stack_tb.sv
`timescale 1ns/1ps
module fpstk_rot_stack_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        op_valid;
   logic [2:0]  op_code;
   logic [2:0]  sel_idx;
   logic        use_sel;
   logic [79:0] wr_data;
   logic        ins_valid;
   logic [7:0]  ins_b0, ins_b1;
   logic [79:0] rd_a, rd_b;
   logic [2:0]  tos_o;
   logic        ovf_o, unf_o;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   localparam logic [79:0] VA = 80'h3FFF_8000_0000_0000_00A1;
   localparam logic [79:0] VB = 80'h4000_C000_0000_0000_00B2;
   localparam logic [79:0] VC = 80'hC001_A000_0000_0000_00C3;
   localparam logic [79:0] VD = 80'h4003_9000_0000_0000_00D4;
   localparam logic [79:0] VE = 80'h7FFE_FFFF_FFFF_FFFF_00E5;

   always #2.5 clk = ~clk;

   fpstk_rot_stack u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .sel_idx(sel_idx), .use_sel(use_sel), .wr_data(wr_data),
      .ins_valid(ins_valid), .ins_b0(ins_b0), .ins_b1(ins_b1),
      .rd_a(rd_a), .rd_b(rd_b), .tos_o(tos_o), .ovf_o(ovf_o), .unf_o(unf_o));

   task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      op_valid = 1'b0; op_code = 3'd0; wr_data = '0;
      ins_valid = 1'b0; ins_b0 = 8'h00; ins_b1 = 8'h00;
   endtask

   // Issue one command for one cycle; return at the following negedge.
   task automatic cmd(input logic [2:0] code, input logic [2:0] sel, input logic [79:0] d);
      @(negedge clk);
      op_valid = 1'b1; op_code = code; sel_idx = sel; wr_data = d;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic instr(input logic [7:0] b0, input logic [7:0] b1);
      @(negedge clk);
      ins_valid = 1'b1; ins_b0 = b0; ins_b1 = b1;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic peek_b(input logic [2:0] sel, input logic sel_on);
      sel_idx = sel; use_sel = sel_on;
      #0.5;
   endtask

   task automatic t_reset();
      check("R1 tos", 80'(tos_o), 80'd0);
      check("R1 ovf", 80'(ovf_o), 80'd0);
      check("R1 unf", 80'(unf_o), 80'd0);
      cmd(3'd2, 3'd0, '0);
      check("R1 pop empty unf", 80'(unf_o), 80'd1);
      check("R4 pop empty tos", 80'(tos_o), 80'd0);
      @(negedge clk);
      check("R11 unf one cycle", 80'(unf_o), 80'd0);
   endtask

   task automatic t_push();
      cmd(3'd1, 3'd0, VA);
      check("R12 push wraps tos", 80'(tos_o), 80'd7);
      cmd(3'd1, 3'd0, VB);
      cmd(3'd1, 3'd0, VC);
      check("R2 tos", 80'(tos_o), 80'd5);
      check("R2 top", rd_a, VC);
      check("R2 ovf low", 80'(ovf_o), 80'd0);
      peek_b(3'd0, 1'b0);
      check("R5 port b below", rd_b, VB);
      peek_b(3'd2, 1'b1);
      check("R5 port b sel 2", rd_b, VA);
      peek_b(3'd0, 1'b0);
   endtask

   task automatic t_wrtop();
      cmd(3'd3, 3'd0, VD);
      check("R6 top", rd_a, VD);
      check("R6 tos", 80'(tos_o), 80'd5);
      peek_b(3'd0, 1'b0);
      check("R6 slot1 kept", rd_b, VB);
   endtask

   task automatic t_xchg_cmd();
      cmd(3'd4, 3'd2, '0);
      check("R7 top now A", rd_a, VA);
      peek_b(3'd2, 1'b1);
      check("R7 slot2 now D", rd_b, VD);
      peek_b(3'd0, 1'b0);
      check("R7 tos", 80'(tos_o), 80'd5);
      check("R7 no unf", 80'(unf_o), 80'd0);
      cmd(3'd4, 3'd0, '0);
      check("R8 self top", rd_a, VA);
      check("R8 self no flag", 80'(unf_o | ovf_o), 80'd0);
      cmd(3'd4, 3'd5, '0);
      check("R7 empty unf", 80'(unf_o), 80'd1);
      check("R7 empty top kept", rd_a, VA);
   endtask

   task automatic t_xchg_dec();
      instr(8'hD9, 8'hCA);
      check("R9 decoded top D", rd_a, VD);
      peek_b(3'd2, 1'b1);
      check("R9 decoded slot2 A", rd_b, VA);
      peek_b(3'd0, 1'b0);
      instr(8'hD9, 8'hD0);
      check("R9 wrong second byte ignored", rd_a, VD);
      instr(8'hD8, 8'hC9);
      check("R9 wrong first byte ignored", rd_a, VD);
      peek_b(3'd0, 1'b0);
      check("R9 ignored slot1", rd_b, VB);
   endtask

   task automatic t_collision();
      @(negedge clk);
      op_valid = 1'b1; op_code = 3'd3; wr_data = VE;
      ins_valid = 1'b1; ins_b0 = 8'hD9; ins_b1 = 8'hC9;
      @(negedge clk);
      idle_inputs();
      check("R10 command applied", rd_a, VE);
      peek_b(3'd0, 1'b0);
      check("R10 decoded exchange dropped", rd_b, VB);
      check("R10 tos", 80'(tos_o), 80'd5);
   endtask

   task automatic t_read();
      cmd(3'd5, 3'd0, '0);
      check("R5 read ok no unf", 80'(unf_o), 80'd0);
      @(negedge clk);
      use_sel = 1'b1; sel_idx = 3'd4; op_valid = 1'b1; op_code = 3'd5;
      @(negedge clk);
      idle_inputs();
      use_sel = 1'b0;
      check("R5 read empty sel unf", 80'(unf_o), 80'd1);
      cmd(3'd6, 3'd0, VA);
      check("R11 unused code no flag", 80'(unf_o | ovf_o), 80'd0);
      check("R11 unused code top", rd_a, VE);
   endtask

   task automatic t_fill_and_drain();
      for (int k = 1; k <= 5; k++) cmd(3'd1, 3'd0, 80'(k));
      check("R2 full tos", 80'(tos_o), 80'd0);
      cmd(3'd1, 3'd0, 80'hFF);
      check("R3 ovf", 80'(ovf_o), 80'd1);
      check("R3 tos kept", 80'(tos_o), 80'd0);
      check("R3 top kept", rd_a, 80'd5);
      for (int k = 5; k >= 1; k--) begin
         check("R4 pop order", rd_a, 80'(k));
         cmd(3'd2, 3'd0, '0);
      end
      check("R4 reach E", rd_a, VE);
      cmd(3'd2, 3'd0, '0);
      check("R4 reach B", rd_a, VB);
      cmd(3'd2, 3'd0, '0);
      check("R4 reach A", rd_a, VA);
      check("R12 tos at 7", 80'(tos_o), 80'd7);
      cmd(3'd2, 3'd0, '0);
      check("R12 pop wraps tos", 80'(tos_o), 80'd0);
      check("R4 last pop no unf", 80'(unf_o), 80'd0);
      cmd(3'd2, 3'd0, '0);
      check("R4 drained unf", 80'(unf_o), 80'd1);
   endtask

   initial begin
      rst_n = 1'b0; sel_idx = 3'd0; use_sel = 1'b0;
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_push();
      t_wrtop();
      t_xchg_cmd();
      t_xchg_dec();
      t_collision();
      t_read();
      t_fill_and_drain();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule